// File: doc/BRIEF.md
# Multi-PHY Transmit Polling Controller

This block drives the transmit side of a cell bus shared by several PHY devices. It keeps asking the attached devices, one after another, whether each can take a whole 53-byte cell. It keeps one ready bit per logical port, which the host reads to choose where the next cell goes. Logical port numbers run from 0 up to a programmable highest port. A writable table turns each logical port into the 5-bit device address that goes on the bus, so the physical addresses can be any set of values.

The host hands over a cell one byte at a time, tagged on its first byte with the destination logical port. The block uses an address slot to put the matching device address on the bus with transmit-enable high. It then streams the bytes with active-low transmit-enable and a start-of-cell flag on the first byte. Polling goes on while the cell is being sent.

Top module: `mphy_tx_poll`

## Requirements
- R1: While `rst` is high at a clock edge, the block resets. After that edge `port_ready` is all zeros, `phy_addr` is 5'h1F (idle), `phy_enb_n` is 1, `phy_soc` is 0 and `in_ready` is 0.
- R2: A polled device address stays on `phy_addr` for exactly one cycle. The next cycle always carries the idle value 5'h1F.
- R3: Polling visits logical ports in rising order, starting at 0. After the port equal to the range value it wraps back to 0. The range value resets to 0, and a write with `range_we` replaces it.
- R4: The lookup table resets so that every logical port maps to address 0. A write with `map_we` stores `map_phy` for port `map_idx`. A write of 5'h1F is discarded and the entry keeps its old value.
- R5: The `phy_clav` level is sampled at the clock edge that ends a port's address cycle. It is stored in `port_ready[port]` and stays there until that port is polled again.
- R6: A new cell can start in an address slot when no transfer is in progress and the host shows `in_valid` with `in_sop`. The block then drives the mapped address of `in_port` for one cycle with `phy_enb_n` high, and clears `port_ready[in_port]`. `in_ready` rises in the next cycle.
- R7: A byte is accepted when `in_valid` and `in_ready` are both high at a clock edge. In the next cycle it appears on `phy_data` with `phy_enb_n` low. `phy_soc` is 1 for the first byte of a cell only. After 53 accepted bytes, `in_ready` falls and the transfer ends.
- R8: If `in_valid` is low during a transfer, no byte is accepted. `phy_enb_n` is then high in the following cycle.
- R9: Device polling continues while a cell is being transferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| range_we | input | 1 | Write strobe for the highest polled logical port |
| range_val | input | PW | New highest polled logical port |
| map_we | input | 1 | Write strobe for the lookup table |
| map_idx | input | PW | Logical port whose table entry is written |
| map_phy | input | 5 | Device address for that logical port |
| port_ready | output | NPORTS | One ready bit per logical port, from the last poll |
| in_valid | input | 1 | Host byte valid |
| in_sop | input | 1 | Host byte is the first byte of a cell |
| in_port | input | PW | Destination logical port, valid with the first byte |
| in_data | input | 8 | Host cell byte |
| in_ready | output | 1 | Block takes a byte at this edge when in_valid is high |
| phy_addr | output | 5 | Device address bus, 5'h1F when idle |
| phy_clav | input | 1 | Cell-available answer from the addressed device |
| phy_enb_n | output | 1 | Active-low transmit-enable |
| phy_soc | output | 1 | Start-of-cell flag |
| phy_data | output | 8 | Cell byte to the devices |

## Verification
A wrong polling pointer or range value shows on `phy_addr` within one poll slot, two cycles, as an address out of order or outside the programmed set. A bad table entry shows the first time its port is polled. A stale or misplaced ready bit shows on `port_ready` one pass after the device's answer changes. A fault in the byte counter shows in the cell itself, as a start flag on the wrong byte, a skipped or repeated byte, or a byte count other than 53. A failure to clear the target's ready bit is visible in the first cycle that transmit-enable is low.

// File: rtl/mphy_pkg.sv
package mphy_pkg;
  localparam int PHY_AW = 5;
  localparam int DATA_W = 8;
  localparam int CELL_BYTES = 53;
  localparam logic [PHY_AW-1:0] IDLE_ADDR = 5'h1F;
  typedef logic [PHY_AW-1:0] phy_addr_t;
endpackage

// File: rtl/mphy_map_table.sv
module mphy_map_table
  import mphy_pkg::*;
#(
  parameter int NPORTS = 8,
  parameter int PW = $clog2(NPORTS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_idx,
  input  phy_addr_t     wr_phy,
  input  logic [PW-1:0] rd_a_idx,
  output phy_addr_t     rd_a_phy,
  input  logic [PW-1:0] rd_b_idx,
  output phy_addr_t     rd_b_phy
);
  phy_addr_t mem [NPORTS];

  // Reserved idle code never enters the table.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NPORTS; i++) mem[i] <= '0;
    end else if (wr_en && wr_phy != IDLE_ADDR) begin
      mem[wr_idx] <= wr_phy;
    end
  end

  assign rd_a_phy = mem[rd_a_idx];
  assign rd_b_phy = mem[rd_b_idx];
endmodule

// File: rtl/mphy_poll_seq.sv
module mphy_poll_seq
  import mphy_pkg::*;
#(
  parameter int NPORTS = 8,
  parameter int PW = $clog2(NPORTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              range_we,
  input  logic [PW-1:0]     range_val,
  input  logic              start,
  input  logic [PW-1:0]     sel_port,
  input  phy_addr_t         sel_phy,
  input  phy_addr_t         poll_phy,
  input  logic              phy_clav,
  output logic [PW-1:0]     ptr,
  output logic              addr_slot,
  output logic [NPORTS-1:0] port_ready,
  output phy_addr_t         phy_addr
);
  localparam logic [PW-1:0] MAXP = PW'(NPORTS - 1);

  logic [PW-1:0] range_q;
  logic          ph_q;
  logic          poll_act_q;

  assign addr_slot = ~ph_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      range_q    <= '0;
      ptr        <= '0;
      ph_q       <= 1'b0;
      poll_act_q <= 1'b0;
      port_ready <= '0;
      phy_addr   <= IDLE_ADDR;
    end else begin
      if (range_we) range_q <= (range_val > MAXP) ? MAXP : range_val;
      ph_q <= ~ph_q;
      if (!ph_q) begin
        // Address slot: selection of a cell target wins over polling.
        if (start) begin
          phy_addr             <= sel_phy;
          poll_act_q           <= 1'b0;
          port_ready[sel_port] <= 1'b0;
        end else begin
          phy_addr   <= poll_phy;
          poll_act_q <= 1'b1;
        end
      end else begin
        // Sample slot: bus returns to idle, answer is latched.
        phy_addr   <= IDLE_ADDR;
        poll_act_q <= 1'b0;
        if (poll_act_q) begin
          port_ready[ptr] <= phy_clav;
          ptr <= (ptr >= range_q) ? '0 : ptr + PW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/mphy_cell_tx.sv
module mphy_cell_tx
  import mphy_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int NB = CELL_BYTES
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          busy,
  output logic          phy_enb_n,
  output logic          phy_soc,
  output logic [DW-1:0] phy_data
);
  localparam int CW = $clog2(NB);
  localparam logic [CW-1:0] LAST = CW'(NB - 1);

  logic [CW-1:0] cnt_q;
  logic          take;

  assign take = busy && in_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      cnt_q     <= '0;
      phy_enb_n <= 1'b1;
      phy_soc   <= 1'b0;
      phy_data  <= '0;
    end else begin
      phy_enb_n <= ~take;
      phy_soc   <= take && (cnt_q == '0);
      if (start) begin
        busy  <= 1'b1;
        cnt_q <= '0;
      end else if (take) begin
        phy_data <= in_data;
        if (cnt_q == LAST) begin
          busy  <= 1'b0;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/mphy_tx_poll.sv
module mphy_tx_poll
  import mphy_pkg::*;
#(
  parameter int NPORTS = 8,
  parameter int PW = $clog2(NPORTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              range_we,
  input  logic [PW-1:0]     range_val,
  input  logic              map_we,
  input  logic [PW-1:0]     map_idx,
  input  logic [4:0]        map_phy,
  output logic [NPORTS-1:0] port_ready,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic [PW-1:0]     in_port,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  output logic [4:0]        phy_addr,
  input  logic              phy_clav,
  output logic              phy_enb_n,
  output logic              phy_soc,
  output logic [7:0]        phy_data
);
  logic [PW-1:0] ptr;
  logic          addr_slot;
  logic          busy;
  logic          start;
  phy_addr_t     poll_phy;
  phy_addr_t     sel_phy;

  assign start    = addr_slot && !busy && in_valid && in_sop;
  assign in_ready = busy;

  mphy_map_table #(.NPORTS(NPORTS), .PW(PW)) u_table (
    .clk(clk), .rst(rst),
    .wr_en(map_we), .wr_idx(map_idx), .wr_phy(map_phy),
    .rd_a_idx(ptr), .rd_a_phy(poll_phy),
    .rd_b_idx(in_port), .rd_b_phy(sel_phy)
  );

  mphy_poll_seq #(.NPORTS(NPORTS), .PW(PW)) u_poll (
    .clk(clk), .rst(rst),
    .range_we(range_we), .range_val(range_val),
    .start(start), .sel_port(in_port), .sel_phy(sel_phy),
    .poll_phy(poll_phy), .phy_clav(phy_clav),
    .ptr(ptr), .addr_slot(addr_slot),
    .port_ready(port_ready), .phy_addr(phy_addr)
  );

  mphy_cell_tx #(.DW(DATA_W), .NB(CELL_BYTES)) u_tx (
    .clk(clk), .rst(rst),
    .start(start), .in_valid(in_valid), .in_data(in_data),
    .busy(busy), .phy_enb_n(phy_enb_n),
    .phy_soc(phy_soc), .phy_data(phy_data)
  );
endmodule

// File: rtl/mphy_tx_poll_chk.sv
module mphy_tx_poll_chk #(
  parameter int NPORTS = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [4:0]        phy_addr,
  input logic              phy_enb_n,
  input logic              phy_soc,
  input logic              in_valid,
  input logic              in_ready,
  input logic [NPORTS-1:0] port_ready
);
  // R1
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (port_ready == '0 && phy_addr == 5'h1F && phy_enb_n && !phy_soc && !in_ready));

  // R2
  a_r2_idle_follows: assert property (@(posedge clk) disable iff (rst)
    (phy_addr != 5'h1F) |=> (phy_addr == 5'h1F));

  // R5, R6: a sample and a clear never land on the same edge
  a_r5_one_bit_moves: assert property (@(posedge clk) disable iff (rst)
    $countones(port_ready ^ $past(port_ready)) <= 1);

  // R6
  a_r6_select_first: assert property (@(posedge clk) disable iff (rst)
    phy_soc |-> ($past(phy_enb_n) && $past(phy_addr) != 5'h1F));

  // R7
  a_r7_soc_in_enable: assert property (@(posedge clk) disable iff (rst)
    phy_soc |-> !phy_enb_n);

  // R7, R8
  a_r8_enable_needs_take: assert property (@(posedge clk) disable iff (rst)
    !phy_enb_n |-> $past(in_valid && in_ready));
endmodule

bind mphy_tx_poll mphy_tx_poll_chk #(.NPORTS(NPORTS)) u_chk (
  .clk(clk), .rst(rst), .phy_addr(phy_addr), .phy_enb_n(phy_enb_n),
  .phy_soc(phy_soc), .in_valid(in_valid), .in_ready(in_ready),
  .port_ready(port_ready)
);

// File: tb/tb_mphy_tx_poll.sv
module tb_mphy_tx_poll;
  localparam int NP = 8;
  localparam int PW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          range_we = 1'b0;
  logic [PW-1:0] range_val = '0;
  logic          map_we = 1'b0;
  logic [PW-1:0] map_idx = '0;
  logic [4:0]    map_phy = '0;
  logic [NP-1:0] port_ready;
  logic          in_valid = 1'b0;
  logic          in_sop = 1'b0;
  logic [PW-1:0] in_port = '0;
  logic [7:0]    in_data = '0;
  logic          in_ready;
  logic [4:0]    phy_addr;
  logic          phy_clav;
  logic          phy_enb_n;
  logic          phy_soc;
  logic [7:0]    phy_data;
  logic [31:0]   clav_map = '0;

  int errs = 0;
  int nchk = 0;
  int tbl [5] = '{3, 5, 7, 9, 22};

  always #10 clk = ~clk;

  assign phy_clav = (phy_addr != 5'h1F) && clav_map[phy_addr];

  mphy_tx_poll #(.NPORTS(NP), .PW(PW)) dut (
    .clk(clk), .rst(rst), .range_we(range_we), .range_val(range_val),
    .map_we(map_we), .map_idx(map_idx), .map_phy(map_phy),
    .port_ready(port_ready), .in_valid(in_valid), .in_sop(in_sop),
    .in_port(in_port), .in_data(in_data), .in_ready(in_ready),
    .phy_addr(phy_addr), .phy_clav(phy_clav), .phy_enb_n(phy_enb_n),
    .phy_soc(phy_soc), .phy_data(phy_data)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; in_sop = 1'b0; clav_map = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr_map(input int idx, input int val);
    @(negedge clk);
    map_we = 1'b1; map_idx = PW'(idx); map_phy = 5'(val);
    @(negedge clk);
    map_we = 1'b0;
  endtask

  task automatic wr_range(input int val);
    @(negedge clk);
    range_we = 1'b1; range_val = PW'(val);
    @(negedge clk);
    range_we = 1'b0;
  endtask

  function automatic int find_pos(input int a, input int n);
    for (int i = 0; i < n; i++) if (tbl[i] == a) return i;
    return -1;
  endfunction

  // Checks poll order over the first n table entries (R2, R3).
  task automatic observe_seq(input int n, input string tag);
    int last = -1;
    bit prev_busy = 1'b0;
    int seen = 0;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      if (phy_addr != 5'h1F) begin
        int p = find_pos(int'(phy_addr), n);
        chk(!prev_busy, "R2 idle cycle between polls", 1, 0);
        chk(p >= 0, {tag, " R3 address in set"}, int'(phy_addr), tbl[0]);
        if (last >= 0) chk(p == (last + 1) % n, {tag, " R3 order"}, p, (last + 1) % n);
        last = p;
        seen++;
      end
      prev_busy = (phy_addr != 5'h1F);
    end
    chk(seen >= 10, {tag, " R9 poll rate"}, seen, 10);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(port_ready == '0, "R1 ready bits", int'(port_ready), 0);
    chk(phy_addr == 5'h1F, "R1 idle address", int'(phy_addr), 31);
    chk(phy_enb_n && !phy_soc && !in_ready, "R1 enable/soc/ready", int'(phy_enb_n), 1);
  endtask

  task automatic t_default_map();
    int zeros = 0;
    do_reset();
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      chk(phy_addr == 5'h00 || phy_addr == 5'h1F, "R4 reset table / R3 range 0", int'(phy_addr), 0);
      if (phy_addr == 5'h00) zeros++;
    end
    chk(zeros >= 5, "R3 port 0 polled", zeros, 5);
  endtask

  task automatic setup_map();
    do_reset();
    for (int i = 0; i < 5; i++) wr_map(i, tbl[i]);
    wr_range(4);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_order();
    setup_map();
    observe_seq(5, "range4");
  endtask

  task automatic t_status();
    setup_map();
    clav_map = '0;
    clav_map[5] = 1'b1; clav_map[22] = 1'b1;
    repeat (24) @(negedge clk);
    chk(port_ready == 8'b0001_0010, "R5 ready bits pass 1", int'(port_ready), 8'b0001_0010);
    clav_map[5] = 1'b0; clav_map[3] = 1'b1;
    repeat (24) @(negedge clk);
    chk(port_ready == 8'b0001_0001, "R5 ready bits pass 2", int'(port_ready), 8'b0001_0001);
  endtask

  task automatic t_range_shrink();
    setup_map();
    wr_range(1);
    repeat (6) @(negedge clk);
    observe_seq(2, "range1");
  endtask

  task automatic t_map_reject();
    setup_map();
    wr_map(0, 31);
    wr_range(0);
    repeat (6) @(negedge clk);
    observe_seq(1, "R4 reserved write dropped");
  endtask

  task automatic t_cell(input int port, input int gap, input logic [7:0] seed);
    int nb = 0, hidx = 0, gap_left = gap, mid_high = 0, polls = 0, guard = 0;
    bit take = 1'b0;
    logic [4:0] pa = 5'h1F;
    logic pe = 1'b1;
    setup_map();
    clav_map = '1;
    repeat (24) @(negedge clk);
    chk(port_ready[port] == 1'b1, "R5 target ready before send", int'(port_ready[port]), 1);
    in_valid = 1'b1; in_sop = 1'b1; in_port = PW'(port); in_data = seed;
    take = in_valid && in_ready;
    while (nb < 53 && guard < 400) begin
      @(negedge clk);
      guard++;
      if (!phy_enb_n) begin
        if (nb == 0) begin
          chk(pe && pa == 5'(tbl[port]), "R6 target selected with enable high", int'(pa), tbl[port]);
          chk(port_ready[port] == 1'b0, "R6 target ready cleared", int'(port_ready[port]), 0);
        end
        chk(phy_soc == (nb == 0), "R7 start-of-cell", int'(phy_soc), int'(nb == 0));
        chk(phy_data == 8'(seed + 8'(nb)), "R7 byte order", int'(phy_data), int'(8'(seed + 8'(nb))));
        if (phy_addr != 5'h1F) polls++;
        nb++;
      end else if (nb > 0) begin
        mid_high++;
      end
      pa = phy_addr; pe = phy_enb_n;
      if (take) hidx++;
      if (hidx >= 53) begin
        in_valid = 1'b0; in_sop = 1'b0;
      end else if (hidx == 20 && gap_left > 0) begin
        in_valid = 1'b0; gap_left--;
      end else begin
        in_valid = 1'b1; in_sop = (hidx == 0); in_data = 8'(seed + 8'(hidx));
      end
      take = in_valid && in_ready;
    end
    in_valid = 1'b0; in_sop = 1'b0;
    chk(nb == 53, "R7 byte count", nb, 53);
    chk(mid_high == gap, "R8 enable high during host pause", mid_high, gap);
    chk(polls >= 10, "R9 polling during transfer", polls, 10);
    repeat (2) @(negedge clk);
    chk(!in_ready && phy_enb_n, "R7 transfer ends", int'(in_ready), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; nchk++;
    $display("FAIL watchdog R1-R9 act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end

  initial begin
    t_reset();
    t_default_map();
    t_order();
    t_status();
    t_range_shrink();
    t_map_reject();
    t_cell(3, 0, 8'h10);
    t_cell(4, 2, 8'hE0);
    t_cell(0, 1, 8'h00);
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end
endmodule